// File: doc/BRIEF.md
# Circular Log Region Pointer Manager

This block tracks the pointers of one flash region that is used as a circular log of pages. New pages are always written at the head, which then moves forward by one. The oldest live page is the tail. A reclaim pointer trails the tail by a fixed reserve of free pages, and a cold pointer leads the tail by a fixed number of blocks. The pages from the tail up to the cold pointer form the cold window, which is the set of blocks the next collection erases.

When the head catches up with the reclaim pointer, the block raises a collection request and refuses further page appends. An external collector empties the cold window and then sends a single-cycle done pulse. On that pulse the tail, reclaim and cold pointers all move forward by the size of the cold window, and appends resume. All pointers are page indices modulo the region size. The reserve and cold sizes are set from percentages with integer arithmetic and rounded to whole blocks, so the tail always stays on a block boundary.

Top module: `log_region_ptrs`

## Requirements
- R1: After reset the head and tail are page 0, the reclaim pointer is TOTAL-RSV_PAGES (36 with the defaults), the cold pointer is COLD_PAGES (8 with the defaults), the collection request is low and write-ready is high.
- R2: While write-ready is high, `wr_page` shows the head index, and an accepted write advances the head by exactly one page on the next clock edge, wrapping from TOTAL-1 to 0. Without an accepted write the head holds.
- R3: The reclaim pointer always sits RSV_PAGES pages before the tail (modulo TOTAL). RSV_PAGES is PAGES_PER_BLK times the ceiling of NUM_BLOCKS*RESERVE_PCT/100, with a minimum of one block (4 pages with the defaults).
- R4: The collection request is high exactly when the head equals the reclaim pointer, and write-ready is low at the same time. A write offered while write-ready is low does not move the head.
- R5: The cold window holds COLD_PAGES pages. This is PAGES_PER_BLK times floor((NUM_BLOCKS-reserve blocks)*COLD_PCT/100), with a minimum of one block (8 with the defaults). The cold pointer equals tail+COLD_PAGES, and `cold_last` equals tail+COLD_PAGES-1, both modulo TOTAL.
- R6: A done pulse while the collection request is high moves the tail, reclaim and cold pointers forward by COLD_PAGES with wraparound on the next edge. It also lowers the request and raises write-ready on that edge.
- R7: A done pulse while the collection request is low changes no pointer.
- R8: If a done pulse and a write request arrive in the same cycle, the write is not taken in that cycle. The same write is taken on the following cycle.
- R9: The tail is always a multiple of PAGES_PER_BLK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Page append request |
| wr_ready | output | 1 | Append can be taken this cycle |
| wr_page | output | PW | Page index the append is written to |
| gc_done | input | 1 | Single-cycle pulse: cold window reclaimed |
| gc_req | output | 1 | Collection needed (head reached reclaim pointer) |
| head_o | output | PW | Head pointer |
| tail_o | output | PW | Tail pointer, first page of the cold window |
| gc_ptr_o | output | PW | Reclaim pointer |
| cold_o | output | PW | Cold pointer, first page after the cold window |
| cold_last_o | output | PW | Last page of the cold window |

## Verification
Two cases can fall in the same cycle: the collector's done pulse and a new page append. The bench holds `wr_valid` high during the cycle in which it pulses `gc_done`, keeps it high for one more cycle, and then checks two things. First, the head has not moved at the done edge while all three trailing pointers have. Second, the head advances by one on the next edge. The bench also fills the log until the head lands exactly on the reclaim pointer. It checks that the last accepted append is the one that raises the request, and that a further append is then refused.

// File: rtl/log_region_pkg.sv
package log_region_pkg;

  // Modular add for a ring of n entries; d must be below n.
  function automatic int unsigned ring_add(int unsigned p, int unsigned d, int unsigned n);
    int unsigned s;
    s = p + d;
    return (s >= n) ? s - n : s;
  endfunction

  // Reserve expressed in blocks: percentage rounded up, never zero.
  function automatic int unsigned reserve_blocks(int unsigned nblk, int unsigned pct);
    int unsigned r;
    r = (nblk * pct + 99) / 100;
    return (r == 0) ? 1 : r;
  endfunction

  // Cold window in blocks: percentage of the live span, rounded down, never zero.
  function automatic int unsigned cold_blocks(int unsigned nblk, int unsigned rsv, int unsigned pct);
    int unsigned c;
    c = ((nblk - rsv) * pct) / 100;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/log_ring_ctr.sv
module log_ring_ctr
  import log_region_pkg::*;
#(
  parameter int unsigned TOTAL = 40,
  parameter int unsigned STEP  = 1,
  parameter int unsigned PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= PW'(ring_add(32'(ptr), STEP, TOTAL));
  end

endmodule

// File: rtl/log_window.sv
module log_window
  import log_region_pkg::*;
#(
  parameter int unsigned TOTAL      = 40,
  parameter int unsigned RSV_PAGES  = 4,
  parameter int unsigned COLD_PAGES = 8,
  parameter int unsigned PW         = 6
) (
  input  logic [PW-1:0] tail,
  output logic [PW-1:0] gc_ptr,
  output logic [PW-1:0] cold_ptr,
  output logic [PW-1:0] cold_last
);

  always_comb begin
    gc_ptr    = PW'(ring_add(32'(tail), TOTAL - RSV_PAGES, TOTAL));
    cold_ptr  = PW'(ring_add(32'(tail), COLD_PAGES, TOTAL));
    cold_last = PW'(ring_add(32'(tail), COLD_PAGES - 1, TOTAL));
  end

endmodule

// File: rtl/log_region_ptrs.sv
module log_region_ptrs
  import log_region_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS    = 10,
  parameter int unsigned PAGES_PER_BLK = 4,
  parameter int unsigned RESERVE_PCT   = 10,
  parameter int unsigned COLD_PCT      = 30,
  localparam int unsigned TOTAL        = NUM_BLOCKS * PAGES_PER_BLK,
  localparam int unsigned PW           = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic [PW-1:0] wr_page,
  input  logic          gc_done,
  output logic          gc_req,
  output logic [PW-1:0] head_o,
  output logic [PW-1:0] tail_o,
  output logic [PW-1:0] gc_ptr_o,
  output logic [PW-1:0] cold_o,
  output logic [PW-1:0] cold_last_o
);

  localparam int unsigned RSV_BLKS   = reserve_blocks(NUM_BLOCKS, RESERVE_PCT);
  localparam int unsigned RSV_PAGES  = RSV_BLKS * PAGES_PER_BLK;
  localparam int unsigned COLD_BLKS  = cold_blocks(NUM_BLOCKS, RSV_BLKS, COLD_PCT);
  localparam int unsigned COLD_PAGES = COLD_BLKS * PAGES_PER_BLK;

  logic [PW-1:0] head_q, tail_q, gc_w, cold_w, cold_last_w;

  // Named events for the checks below.
  logic wr_fire, gc_fire, done_stray;

  assign gc_req     = (head_q == gc_w);
  assign wr_ready   = !gc_req;
  assign wr_fire    = wr_valid && wr_ready;
  assign gc_fire    = gc_done && gc_req;
  assign done_stray = gc_done && !gc_req;

  log_ring_ctr #(.TOTAL(TOTAL), .STEP(1), .PW(PW)) u_head (
    .clk(clk), .rst_n(rst_n), .adv(wr_fire), .ptr(head_q)
  );

  log_ring_ctr #(.TOTAL(TOTAL), .STEP(COLD_PAGES), .PW(PW)) u_tail (
    .clk(clk), .rst_n(rst_n), .adv(gc_fire), .ptr(tail_q)
  );

  log_window #(.TOTAL(TOTAL), .RSV_PAGES(RSV_PAGES), .COLD_PAGES(COLD_PAGES), .PW(PW)) u_win (
    .tail(tail_q), .gc_ptr(gc_w), .cold_ptr(cold_w), .cold_last(cold_last_w)
  );

  assign wr_page     = head_q;
  assign head_o      = head_q;
  assign tail_o      = tail_q;
  assign gc_ptr_o    = gc_w;
  assign cold_o      = cold_w;
  assign cold_last_o = cold_last_w;

  // R2: head moves only on an accepted append.
  p_head_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> head_q != $past(head_q));
  p_head_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(head_q));
  // R4: a pending collection freezes the head.
  p_head_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gc_req |=> $stable(head_q));
  // R6: a taken done pulse clears the request.
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gc_fire |=> !gc_req && wr_ready);
  // R7: a stray done pulse leaves the tail alone.
  p_stray_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_stray |=> $stable(tail_q));
  // R9: tail stays block aligned.
  p_tail_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tail_q) % PAGES_PER_BLK) == 0);

endmodule

// File: tb/log_region_ptrs_tb.sv
module log_region_ptrs_tb;

  localparam int NB = 10, PPB = 4;
  localparam int NPG = NB * PPB;
  localparam int RES = 4;
  localparam int COLD = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_valid = 1'b0, gc_done = 1'b0;
  logic wr_ready, gc_req;
  logic [5:0] wr_page, head_o, tail_o, gc_ptr_o, cold_o, cold_last_o;

  int checks = 0, errors = 0;
  int m_head = 0, m_tail = 0;

  always #4 clk = ~clk;

  log_region_ptrs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_page(wr_page), .gc_done(gc_done), .gc_req(gc_req), .head_o(head_o),
    .tail_o(tail_o), .gc_ptr_o(gc_ptr_o), .cold_o(cold_o), .cold_last_o(cold_last_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int m_gc();
    return (m_tail + NPG - RES) % NPG;
  endfunction

  task automatic check_all(string tag);
    check({tag, " R2 head"}, int'(head_o), m_head);
    check({tag, " R9 tail"}, int'(tail_o), m_tail);
    check({tag, " R3 gc_ptr"}, int'(gc_ptr_o), m_gc());
    check({tag, " R5 cold"}, int'(cold_o), (m_tail + COLD) % NPG);
    check({tag, " R5 cold_last"}, int'(cold_last_o), (m_tail + COLD - 1) % NPG);
    check({tag, " R4 gc_req"}, int'(gc_req), int'(m_head == m_gc()));
    check({tag, " R4 wr_ready"}, int'(wr_ready), int'(m_head != m_gc()));
    check({tag, " R9 align"}, int'(tail_o) % PPB, 0);
  endtask

  task automatic write_one(string tag);
    bit can;
    @(negedge clk);
    wr_valid = 1'b1;
    #1;
    can = (m_head != m_gc());
    if (can) check({tag, " R2 wr_page"}, int'(wr_page), m_head);
    @(negedge clk);
    wr_valid = 1'b0;
    if (can) m_head = (m_head + 1) % NPG;
    #1 check_all(tag);
  endtask

  task automatic fill_to_gc(string tag);
    while (m_head != m_gc()) write_one(tag);
  endtask

  task automatic t_reset();
    check_all("reset R1");
    check("R1 gc_ptr", int'(gc_ptr_o), 36);
    check("R1 cold", int'(cold_o), 8);
  endtask

  task automatic t_blocked();
    fill_to_gc("fill");
    check("R4 req at gc", int'(gc_req), 1);
    write_one("blocked R4");
    check("R4 head held", int'(head_o), 36);
  endtask

  // R8 with R6: done and write together.
  task automatic t_done_and_write();
    @(negedge clk);
    wr_valid = 1'b1;
    gc_done  = 1'b1;
    @(negedge clk);
    gc_done = 1'b0;
    m_tail = (m_tail + COLD) % NPG;
    #1 check_all("done R6");
    check("R8 head not taken", int'(head_o), 36);
    check("R6 tail", int'(tail_o), 8);
    @(negedge clk);
    wr_valid = 1'b0;
    m_head = (m_head + 1) % NPG;
    #1 check_all("next R8");
    check("R8 head taken", int'(head_o), 37);
  endtask

  task automatic t_stray_done();
    @(negedge clk);
    gc_done = 1'b1;
    @(negedge clk);
    gc_done = 1'b0;
    #1 check_all("stray R7");
    check("R7 tail kept", int'(tail_o), 8);
  endtask

  task automatic do_done(string tag);
    @(negedge clk);
    gc_done = 1'b1;
    @(negedge clk);
    gc_done = 1'b0;
    m_tail = (m_tail + COLD) % NPG;
    #1 check_all(tag);
  endtask

  task automatic t_rounds();
    for (int r = 0; r < 4; r++) begin
      fill_to_gc("round R2");
      do_done("round R6");
    end
    check("R6 tail wrap", int'(tail_o), 0);
    check("R3 gc wrap", int'(gc_ptr_o), 36);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 t_reset();
    t_blocked();
    t_done_and_write();
    t_stray_done();
    t_rounds();
    finish_run();
  end

endmodule